// File: doc/BRIEF.md
# Per-Group Test Pattern Generator

The block sits in the transmit sample path of a multi-stream converter link. It forwards live sample words, or replaces them with a generated test pattern, separately for three groups of streams. The first two groups are receive groups of `RX_LANES` streams each. The third group is a feedback group of `FB_LANES` streams. On each clock it presents one sample word per stream. Framing, lane mapping, scrambling and serialization are handled downstream.

Each group has one 8-bit control byte. Software writes and reads it through a small address/data port. The byte holds two fields:
- a pattern selector in bits 2..0;
- a ramp step field in bits 6..3.

Bit 7 is reserved. The control bytes and the generator states are independent per group, so a test can drive a ramp on one group while another carries live traffic.

Top module: `tpg_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three control bytes clear to 0. From then on every group passes `din` straight to `dout`, and `reg_rdata` reads 0 at every address.
- R2: Bit 7 of a control byte is reserved. Whatever is written there, it reads back as 0.
- R3: Selector codes 0, 3, 5, 6 and 7 mean no test. Each stream of the group outputs its own `din` word unchanged in the same cycle.
- R4: Selector code 1 produces the short sequence 0x0000, 0xFFFF, 0x5555, 0xAAAA, repeating. It starts at 0x0000 in the first cycle after the selecting write. Every stream of the group carries the same word.
- R5: Selector code 2 produces a ramp. It starts at 0 in the first cycle after the selecting write and advances each clock by 1 plus the bits 6..3 value, so the step is 1 to 16. It wraps modulo 2^16.
- R6: Selector code 4 alternates all-zeros and all-ones words every clock. It starts with all-zeros in the first cycle after the selecting write.
- R7: A write with `reg_wr` high at address 0, 1 or 2 updates that group's byte at that clock edge. The output follows the new setting from the next cycle. `reg_rdata` returns the stored byte of the group at `reg_addr`, and reads 0 at address 3.
- R8: Address 0 controls streams 0..RX_LANES-1. Address 1 controls streams RX_LANES..2*RX_LANES-1. Address 2 controls the remaining FB_LANES feedback streams. Stream s occupies `din`/`dout` bits [16*s+15:16*s].
- R9: A write to one group leaves the control bytes, pattern progress and outputs of the other groups unchanged.
- R10: A write that keeps the selector value (for example, only a new ramp step) does not restart the generator. A write to address 3 changes no control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control byte at `reg_addr` |
| reg_addr | input | 2 | Group select: 0, 1 = receive groups, 2 = feedback group |
| reg_wdata | input | 8 | Write data (bits 6..3 ramp step, bits 2..0 selector) |
| reg_rdata | output | 8 | Read data for the control byte at `reg_addr` |
| din | input | 160 | Live sample words, 16 bits per stream, 10 streams |
| dout | output | 160 | Outgoing sample words, 16 bits per stream |

## Verification
A stuck or mis-advanced generator counter shows at the group's `dout` words in the first cycle after the pattern begins: a ramp value off by the step, a repeated short-sequence word, or a missed toggle. A wrong restart decision shows in the cycle right after a write, as a sequence that does or does not begin at its first value. A decode error between groups shows as a neighbouring group's streams leaving live data or changing pattern phase on that same cycle. The reference model predicts every stream word and the read-back byte on every clock, so each such fault is seen within one cycle of its cause.

// File: rtl/tpg_pkg.sv
// Package: shared types and selector decode for the test pattern generator.
// Assumes selector codes outside {1,2,4} mean "no test".
package tpg_pkg;

    localparam int CTRL_W   = 8;
    localparam int SEL_W    = 3;
    localparam int STEP_W   = 4;
    localparam int N_GROUPS = 3;

    // Stored control of one group: step field above selector, as in the byte layout
    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [SEL_W-1:0]  sel;
    } grp_ctrl_t;

    typedef enum logic [1:0] {
        PAT_PASS,
        PAT_SHORT,
        PAT_RAMP,
        PAT_ALT
    } pat_kind_e;

    // Map a raw selector code onto the pattern it requests
    function automatic pat_kind_e decode_sel(input logic [SEL_W-1:0] code);
        case (code)
            3'd1:    return PAT_SHORT;
            3'd2:    return PAT_RAMP;
            3'd4:    return PAT_ALT;
            default: return PAT_PASS;
        endcase
    endfunction

endpackage

// File: rtl/tpg_ctrl_regs.sv
// Module: tpg_ctrl_regs
// Holds one control byte per stream group and decodes the write/read port.
// Assumes one access per clock. Address values at or above GROUPS hit nothing
// and read back 0. The reserved top bit is cleared when the byte is stored.
module tpg_ctrl_regs
    import tpg_pkg::*;
#(
    parameter int GROUPS = N_GROUPS,
    parameter int ADDR_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [CTRL_W-1:0]        wdata_i,
    output grp_ctrl_t [GROUPS-1:0]   ctrl_o,
    output logic [GROUPS-1:0]        hit_o,
    output logic [CTRL_W-1:0]        rdata_o
);

    localparam logic [CTRL_W-1:0] KEEP_MASK = {1'b0, {(CTRL_W-1){1'b1}}};

    logic [CTRL_W-1:0] byte_q [GROUPS];

    for (genvar g = 0; g < GROUPS; g++) begin : g_reg
        assign hit_o[g]  = wr_i && (addr_i == ADDR_W'(g));
        assign ctrl_o[g] = byte_q[g][CTRL_W-2:0];

        // Store a written byte with the reserved bit forced low
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q[g] <= '0;
            else if (hit_o[g])
                byte_q[g] <= wdata_i & KEEP_MASK;
        end

        AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && addr_i == ADDR_W'(g)) |=> (ctrl_o[g] == $past(wdata_i[CTRL_W-2:0]))); // R7

        AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_i && addr_i == ADDR_W'(g)) |=> $stable(ctrl_o[g])); // R9
    end

    // Return the byte of the addressed group, zero for unused addresses
    always_comb begin
        rdata_o = '0;
        for (int g = 0; g < GROUPS; g++)
            if (addr_i == ADDR_W'(g))
                rdata_o = byte_q[g];
    end

endmodule

// File: rtl/tpg_group_gen.sv
// Module: tpg_group_gen
// Pattern source for one stream group. A single counter serves every pattern:
// its low two bits index the short sequence, bit 0 drives the alternating
// pattern, and the full width is the ramp. The counter restarts whenever a
// write changes the selector value. It holds at zero while no test is selected.
// Assumes SAMPLE_W is even.
module tpg_group_gen
    import tpg_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  grp_ctrl_t            ctrl_i,
    input  logic                 hit_i,
    input  logic [SEL_W-1:0]     new_sel_i,
    output logic [SAMPLE_W-1:0]  pat_o,
    output logic                 use_pat_o
);

    // Checkerboard word; lsb_one selects 0x..55 versus 0x..AA
    function automatic logic [SAMPLE_W-1:0] checker_word(input logic lsb_one);
        logic [SAMPLE_W-1:0] w;
        for (int i = 0; i < SAMPLE_W; i++)
            w[i] = ((i % 2) == 0) ? lsb_one : !lsb_one;
        return w;
    endfunction

    localparam logic [SAMPLE_W-1:0] CHK_LO = checker_word(1'b1);
    localparam logic [SAMPLE_W-1:0] CHK_HI = checker_word(1'b0);

    pat_kind_e           kind;
    logic                restart;
    logic [SAMPLE_W-1:0] step;
    logic [SAMPLE_W-1:0] cnt_q;

    assign kind      = decode_sel(ctrl_i.sel);
    assign restart   = hit_i && (new_sel_i != ctrl_i.sel);
    assign step      = SAMPLE_W'(ctrl_i.step) + SAMPLE_W'(1);
    assign use_pat_o = (kind != PAT_PASS);

    // Advance the shared counter by the ramp step or by one, per pattern
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt_q <= '0;
        else begin
            case (kind)
                PAT_PASS: cnt_q <= '0;
                PAT_RAMP: cnt_q <= cnt_q + step;
                default:  cnt_q <= cnt_q + SAMPLE_W'(1);
            endcase
        end
    end

    // Form the pattern word from the counter
    always_comb begin
        case (kind)
            PAT_SHORT: begin
                case (cnt_q[1:0])
                    2'd0:    pat_o = '0;
                    2'd1:    pat_o = '1;
                    2'd2:    pat_o = CHK_LO;
                    default: pat_o = CHK_HI;
                endcase
            end
            PAT_RAMP: pat_o = cnt_q;
            PAT_ALT:  pat_o = cnt_q[0] ? '1 : '0;
            default:  pat_o = '0;
        endcase
    end

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == PAT_RAMP && !restart) |=> (cnt_q == $past(cnt_q) + $past(step))); // R5

    AST_SHORT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == PAT_SHORT && !restart) |=> (cnt_q[1:0] == $past(cnt_q[1:0]) + 2'd1)); // R4

    AST_ALT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == PAT_ALT && !restart) |=> (pat_o == ~$past(pat_o))); // R6

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && decode_sel(new_sel_i) != PAT_PASS) |=> (pat_o == '0)); // R10

endmodule

// File: rtl/tpg_stream_mux.sv
// Module: tpg_stream_mux
// Per-stream selection between live data and the owning group's pattern.
// Assumes the stream order: receive group 0, receive group 1, then feedback.
module tpg_stream_mux
    import tpg_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int RX_LANES = 4,
    parameter int FB_LANES = 2
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [(2*RX_LANES+FB_LANES)*SAMPLE_W-1:0]    din_i,
    input  logic [N_GROUPS-1:0][SAMPLE_W-1:0]            pat_i,
    input  logic [N_GROUPS-1:0]                          use_pat_i,
    output logic [(2*RX_LANES+FB_LANES)*SAMPLE_W-1:0]    dout_o
);

    localparam int N_STREAMS = 2 * RX_LANES + FB_LANES;

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_stream
        localparam int GRP = (s < RX_LANES) ? 0 : ((s < 2 * RX_LANES) ? 1 : 2);

        // Pick the pattern word when the owning group is under test
        assign dout_o[s*SAMPLE_W +: SAMPLE_W] =
            use_pat_i[GRP] ? pat_i[GRP] : din_i[s*SAMPLE_W +: SAMPLE_W];

        AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
            !use_pat_i[GRP] |-> (dout_o[s*SAMPLE_W +: SAMPLE_W] == din_i[s*SAMPLE_W +: SAMPLE_W])); // R3
    end

endmodule

// File: rtl/tpg_top.sv
// Module: tpg_top
// Test pattern generator for three stream groups (two receive, one feedback).
// A control byte per group selects live data or a generated pattern.
// The output path is combinational from din and the registered generator state.
// Assumes a synchronous active-low reset held for at least one clock edge.
module tpg_top
    import tpg_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int RX_LANES = 4,
    parameter int FB_LANES = 2,
    parameter int ADDR_W   = 2
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       reg_wr,
    input  logic [ADDR_W-1:0]                          reg_addr,
    input  logic [CTRL_W-1:0]                          reg_wdata,
    output logic [CTRL_W-1:0]                          reg_rdata,
    input  logic [(2*RX_LANES+FB_LANES)*SAMPLE_W-1:0]  din,
    output logic [(2*RX_LANES+FB_LANES)*SAMPLE_W-1:0]  dout
);

    grp_ctrl_t [N_GROUPS-1:0]          ctrl;
    logic [N_GROUPS-1:0]               hit;
    logic [N_GROUPS-1:0][SAMPLE_W-1:0] pat;
    logic [N_GROUPS-1:0]               use_pat;

    tpg_ctrl_regs #(
        .GROUPS (N_GROUPS),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .ctrl_o  (ctrl),
        .hit_o   (hit),
        .rdata_o (reg_rdata)
    );

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_gen
        tpg_group_gen #(
            .SAMPLE_W (SAMPLE_W)
        ) u_gen (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_i    (ctrl[g]),
            .hit_i     (hit[g]),
            .new_sel_i (reg_wdata[SEL_W-1:0]),
            .pat_o     (pat[g]),
            .use_pat_o (use_pat[g])
        );
    end

    tpg_stream_mux #(
        .SAMPLE_W (SAMPLE_W),
        .RX_LANES (RX_LANES),
        .FB_LANES (FB_LANES)
    ) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .din_i     (din),
        .pat_i     (pat),
        .use_pat_i (use_pat),
        .dout_o    (dout)
    );

endmodule

// File: tb/test_tpg_top.sv
// Bench for tpg_top: a behavioural reference model predicts every stream word
// and the read-back byte each cycle; inputs change at the falling edge.
module test_tpg_top;

    localparam int W   = 16;
    localparam int RXN = 4;
    localparam int FBN = 2;
    localparam int NS  = 2 * RXN + FBN;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_addr = '0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic [NS*W-1:0] din = '0;
    logic [NS*W-1:0] dout;

    always #5 clk = ~clk;

    tpg_top i_tpg_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .din       (din),
        .dout      (dout)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string phase  = "R1 reset";

    // Reference model state per group
    logic [2:0]  m_sel  [3];
    logic [3:0]  m_step [3];
    logic [15:0] m_cnt  [3];

    function automatic int grp_of(int s);
        if (s < RXN) return 0;
        if (s < 2 * RXN) return 1;
        return 2;
    endfunction

    function automatic string sel_tag(int g);
        case (m_sel[g])
            3'd1:    return "R4";
            3'd2:    return "R5";
            3'd4:    return "R6";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [15:0] exp_word(int g, logic [15:0] live);
        case (m_sel[g])
            3'd1: begin
                case (m_cnt[g] % 4)
                    0:       return 16'h0000;
                    1:       return 16'hFFFF;
                    2:       return 16'h5555;
                    default: return 16'hAAAA;
                endcase
            end
            3'd2:    return m_cnt[g];
            3'd4:    return (m_cnt[g] % 2 == 1) ? 16'hFFFF : 16'h0000;
            default: return live;
        endcase
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, then step the model
    task automatic cycle(bit wr, logic [1:0] a, logic [7:0] d);
        logic [15:0] nxt;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        for (int s = 0; s < NS; s++) din[s*W +: W] = 16'($urandom);
        #1;
        if (rst_n || phase == "R1 reset") begin
            for (int s = 0; s < NS; s++) begin
                int g = grp_of(s);
                check($sformatf("%s %s stream %0d", sel_tag(g), phase, s),
                      dout[s*W +: W], exp_word(g, din[s*W +: W]));
            end
            if (a < 2'd3)
                check($sformatf("R7 R2 read %s addr %0d", phase, a), {8'h00, reg_rdata},
                      {8'h00, 1'b0, m_step[a], m_sel[a]});
            else
                check($sformatf("R7 read %s addr 3", phase), {8'h00, reg_rdata}, 16'h0000);
        end
        @(posedge clk);
        for (int g = 0; g < 3; g++) begin
            if (!rst_n) begin
                m_sel[g] = '0; m_step[g] = '0; m_cnt[g] = '0;
            end else begin
                case (m_sel[g])
                    3'd1, 3'd4: nxt = m_cnt[g] + 16'd1;
                    3'd2:       nxt = m_cnt[g] + 16'(m_step[g]) + 16'd1;
                    default:    nxt = 16'd0;
                endcase
                if (wr && a == 2'(g)) begin
                    m_cnt[g]  = (d[2:0] != m_sel[g]) ? 16'd0 : nxt;
                    m_sel[g]  = d[2:0];
                    m_step[g] = d[6:3];
                end else begin
                    m_cnt[g] = nxt;
                end
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 2'(i % 4), 8'h00);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < 3; g++) begin
            m_sel[g] = '0; m_step[g] = '0; m_cnt[g] = '0;
        end
        // R1: reset clears bytes, write during reset is ignored
        repeat (2) @(posedge clk);
        for (int a = 0; a < 4; a++) cycle(1'b0, 2'(a), 8'h00);
        cycle(1'b1, 2'd0, 8'h0A);
        idle(2);
        rst_n = 1'b1;
        idle(4);

        phase = "R4 short";
        cycle(1'b1, 2'd0, 8'h01);
        idle(9);

        phase = "R6 alt";
        cycle(1'b1, 2'd2, 8'h04);
        idle(7);

        phase = "R5 ramp wrap";
        cycle(1'b1, 2'd1, 8'h7A);
        idle(4200);

        phase = "R10 same selector";
        cycle(1'b1, 2'd1, 8'h02);
        idle(5);
        phase = "R10 addr3 ignored";
        cycle(1'b1, 2'd3, 8'h01);
        idle(4);

        phase = "R2 reserved bit";
        cycle(1'b1, 2'd0, 8'hFF);
        for (int i = 0; i < 3; i++) cycle(1'b0, 2'd0, 8'h00);

        phase = "R3 unused codes";
        for (int c = 0; c < 4; c++) begin
            cycle(1'b1, 2'd0, (c == 3) ? 8'h00 : 8'(3 + c + (c > 0 ? 1 : 0)));
            idle(3);
        end

        phase = "R9 isolation";
        cycle(1'b1, 2'd0, 8'h01);
        idle(4);
        cycle(1'b1, 2'd0, 8'h04);
        idle(4);

        phase = "R8 stream map";
        cycle(1'b1, 2'd0, 8'h01);
        cycle(1'b1, 2'd1, 8'h04);
        cycle(1'b1, 2'd2, 8'h1A);
        idle(10);

        phase = "R7 write timing";
        for (int i = 0; i < 60; i++) cycle(1'b1, 2'(i % 4), 8'($urandom));
        idle(4);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule